// File: doc/BRIEF.md
# In-System Flash Erase and Program Sequencer

This block runs a complete in-system flash programming session on a target device. It does not move the TAP itself. It sends a stream of abstract commands to a lower-level JTAG driver: load a 10-bit instruction, shift a data word of a given length, or stay in run-test/idle for a given number of TCK cycles. It waits for the driver's done handshake after each command before it issues the next.

A session starts with a one-cycle `start` pulse. The sequencer enters programming mode and erases three sectors in a fixed order. It then programs two blocks, taking the words from an external expected-image read port. A sector select comes before every erase and program step. Each programmed word is followed by a timed idle, which acts as the program pulse.

Once both blocks are written, an external verification result is sampled. If verification passed, the first header words of block 0 are written once more, with the image-valid bit cleared in word 0. The session then leaves programming mode, drops `busy` and pulses `done`, and holds the sampled result on `pass`.

Top module: `isp_session_seq`

## Requirements
- R1: After reset, `busy`, `done`, `pass` and `cmd_valid` are all 0.
- R2: `cmd_valid` stays high, with every command field stable, until a cycle in which `cmd_done` is 1. In the cycle after that it is low. Only one command is outstanding at a time.
- R3: The first two commands of a session are an instruction load of 0x2CC and an idle of 18003 cycles.
- R4: A sector select is three commands: instruction 0x203, an idle of 93, and a 13-bit data shift of the sector number. Every data shift has a length of 13 or 16.
- R5: After the entry step, sectors 0x011, 0x001 and 0x000 are erased in that order. Each erase is a select, then instruction 0x2F2, then an idle of 9000003 cycles.
- R6: Block 0 (3328 words, sector 0) is programmed first and block 1 (512 words, sector 1) second. Each block is a select, instruction 0x2F4 and an idle of 93. Then, for each word in ascending address order, there is a 16-bit data shift of the read-port word and an idle of 1800. The read port is addressed by `rd_blk` (0 for block 0, 1 for block 1) and `rd_idx`, and returns `rd_data` in the same cycle.
- R7: `verify_ok` is sampled once, after the last block-1 word. If it is 1, the sequencer selects sector 0, issues 0x2F4 and an idle of 93, then writes block-0 words 0 to 3, each followed by an idle of 1800. Word 0 is ANDed with 0xFBFF.
- R8: If the sampled `verify_ok` is 0, the header rewrite is skipped and the session goes straight to the exit step.
- R9: A session ends with instruction 0x201, an idle of 18003, instruction 0x3FF and an idle of 18000.
- R10: `busy` rises in the cycle after an accepted `start` and stays high until the last command completes. When `busy` falls, `done` is 1 for exactly one cycle. `pass` shows the sampled verification result from then until the next `start`.
- R11: A `start` pulse while `busy` is high is ignored. It neither restarts nor extends the session, and it does not cause a second session.
- R12: Command kind encoding is 0 for instruction, 1 for data shift and 2 for idle. Fields a command does not use are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a session when idle |
| verify_ok | input | 1 | External verification result |
| busy | output | 1 | Session in progress |
| done | output | 1 | One-cycle end-of-session pulse |
| pass | output | 1 | Sampled verification result |
| cmd_valid | output | 1 | Command outstanding to the driver |
| cmd_kind | output | 2 | 0 instruction, 1 data shift, 2 idle |
| cmd_ir | output | 10 | Instruction value |
| cmd_dr_len | output | 5 | Data shift length in bits |
| cmd_dr_data | output | 16 | Data shift value |
| cmd_idle | output | 24 | Idle length in TCK cycles |
| cmd_done | input | 1 | Driver finished the outstanding command |
| rd_blk | output | 1 | Expected-image block select |
| rd_idx | output | IDX_W | Expected-image word index |
| rd_data | input | 16 | Expected-image word |

## Verification
The bench compares the full command stream against an independently built list, so several kinds of error show up as a mismatched entry:
- a sequencer that loses its place at a block boundary repeats or drops a word;
- one that reads the wrong block sends the wrong data;
- one that forgets to clear the image-valid bit in the rewritten header word 0 sends 0xA5C3 where 0xA1C3 is expected.

The driver model holds `cmd_done` back for zero to two cycles. A design that advances without the handshake, or changes fields while a command is outstanding, therefore fails the stability checks.

A run with verification failing checks that the header rewrite is skipped and that `pass` goes to 0. A stray `start` in mid-session would, in a wrong design, restart the entry step or produce a second `done`.

// File: rtl/isp_seq_pkg.sv
// Shared widths, protocol constants and types for the ISP session sequencer.
package isp_seq_pkg;
    localparam int IR_W   = 10;
    localparam int LEN_W  = 5;
    localparam int DATA_W = 16;
    localparam int IDLE_W = 24;
    localparam int SEC_W  = 13;

    localparam logic [IR_W-1:0] IR_ENTER   = 10'h2CC;
    localparam logic [IR_W-1:0] IR_SEL     = 10'h203;
    localparam logic [IR_W-1:0] IR_ERASE   = 10'h2F2;
    localparam logic [IR_W-1:0] IR_PROG    = 10'h2F4;
    localparam logic [IR_W-1:0] IR_LEAVE   = 10'h201;
    localparam logic [IR_W-1:0] IR_BYPASS  = 10'h3FF;

    typedef enum logic [1:0] {
        CK_IR   = 2'd0,
        CK_DR   = 2'd1,
        CK_IDLE = 2'd2
    } cmd_kind_e;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_ENTER,
        PH_ERASE,
        PH_PHDR,
        PH_PWORD,
        PH_CHECK,
        PH_FHDR,
        PH_FWORD,
        PH_EXIT
    } phase_e;

    typedef struct packed {
        cmd_kind_e            kind;
        logic [IR_W-1:0]      ir;
        logic [LEN_W-1:0]     len;
        logic [DATA_W-1:0]    data;
        logic [IDLE_W-1:0]    idle;
    } isp_cmd_t;
endpackage

// File: rtl/isp_cmd_gen.sv
// Command builder: maps (phase, micro-step, sector slot, word) to one driver command.
// Assumes the phase/step registers are stable while the result is latched.
// Purely combinational; unused fields of a command are forced to zero.
module isp_cmd_gen
    import isp_seq_pkg::*;
#(
    parameter int          IDX_W       = 12,
    parameter logic [23:0] ENTER_IDLE  = 24'd18003,
    parameter logic [23:0] SETUP_IDLE  = 24'd93,
    parameter logic [23:0] ERASE_IDLE  = 24'd9000003,
    parameter logic [23:0] WORD_IDLE   = 24'd1800,
    parameter logic [23:0] LEAVE_IDLE  = 24'd18003,
    parameter logic [23:0] BYPASS_IDLE = 24'd18000,
    parameter logic [15:0] HDR_MASK    = 16'hFBFF
) (
    input  phase_e              phase,
    input  logic [2:0]          ustep,
    input  logic [1:0]          sel,
    input  logic [IDX_W-1:0]    widx,
    input  logic [DATA_W-1:0]   word,
    output isp_cmd_t            cmd,
    output logic                last,
    output logic                has_cmd
);
    localparam logic [SEC_W-1:0] SEC_ER0 = 13'h0011;
    localparam logic [SEC_W-1:0] SEC_ER1 = 13'h0001;
    localparam logic [SEC_W-1:0] SEC_ER2 = 13'h0000;
    localparam logic [SEC_W-1:0] SEC_B0  = 13'h0000;
    localparam logic [SEC_W-1:0] SEC_B1  = 13'h0001;

    logic [SEC_W-1:0] sec_id;

    // Pick the sector number addressed by the current select step.
    always_comb begin
        sec_id = SEC_B0;
        if (phase == PH_ERASE) begin
            case (sel)
                2'd0:    sec_id = SEC_ER0;
                2'd1:    sec_id = SEC_ER1;
                default: sec_id = SEC_ER2;
            endcase
        end else if (phase == PH_PHDR && sel[0]) begin
            sec_id = SEC_B1;
        end
    end

    // Build the command for the current micro-step and flag the last step of a phase.
    always_comb begin
        cmd     = '0;
        last    = 1'b0;
        has_cmd = 1'b1;
        case (phase)
            PH_ENTER: begin
                last = (ustep == 3'd1);
                if (ustep == 3'd0) begin cmd.kind = CK_IR;   cmd.ir   = IR_ENTER;   end
                else               begin cmd.kind = CK_IDLE; cmd.idle = ENTER_IDLE; end
            end
            PH_ERASE, PH_PHDR, PH_FHDR: begin
                last = (ustep == 3'd4);
                case (ustep)
                    3'd0: begin cmd.kind = CK_IR;   cmd.ir = IR_SEL;       end
                    3'd1: begin cmd.kind = CK_IDLE; cmd.idle = SETUP_IDLE; end
                    3'd2: begin
                        cmd.kind = CK_DR;
                        cmd.len  = LEN_W'(SEC_W);
                        cmd.data = DATA_W'(sec_id);
                    end
                    3'd3: begin
                        cmd.kind = CK_IR;
                        cmd.ir   = (phase == PH_ERASE) ? IR_ERASE : IR_PROG;
                    end
                    default: begin
                        cmd.kind = CK_IDLE;
                        cmd.idle = (phase == PH_ERASE) ? ERASE_IDLE : SETUP_IDLE;
                    end
                endcase
            end
            PH_PWORD, PH_FWORD: begin
                last = (ustep == 3'd1);
                if (ustep == 3'd0) begin
                    cmd.kind = CK_DR;
                    cmd.len  = LEN_W'(DATA_W);
                    cmd.data = (phase == PH_FWORD && widx == '0) ? (word & HDR_MASK) : word;
                end else begin
                    cmd.kind = CK_IDLE;
                    cmd.idle = WORD_IDLE;
                end
            end
            PH_EXIT: begin
                last = (ustep == 3'd3);
                case (ustep)
                    3'd0:    begin cmd.kind = CK_IR;   cmd.ir   = IR_LEAVE;    end
                    3'd1:    begin cmd.kind = CK_IDLE; cmd.idle = LEAVE_IDLE;  end
                    3'd2:    begin cmd.kind = CK_IR;   cmd.ir   = IR_BYPASS;   end
                    default: begin cmd.kind = CK_IDLE; cmd.idle = BYPASS_IDLE; end
                endcase
            end
            default: has_cmd = 1'b0;
        endcase
    end
endmodule

// File: rtl/isp_progress.sv
// Session position tracker: phase, micro-step, sector/block slot and word index.
// Assumes 'go' only while idle and 'advance' at most once per completed command
// (or once for the verify-sample phase). HDR_WORDS must not exceed BLK0_WORDS.
module isp_progress
    import isp_seq_pkg::*;
#(
    parameter int BLK0_WORDS = 3328,
    parameter int BLK1_WORDS = 512,
    parameter int HDR_WORDS  = 4,
    parameter int ERASE_N    = 3,
    parameter int IDX_W      = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             advance,
    input  logic             last,
    input  logic             verify_ok,
    output phase_e           phase,
    output logic [2:0]       ustep,
    output logic [1:0]       sel,
    output logic [IDX_W-1:0] widx
);
    localparam logic [IDX_W-1:0] B0_LAST  = IDX_W'(BLK0_WORDS - 1);
    localparam logic [IDX_W-1:0] B1_LAST  = IDX_W'(BLK1_WORDS - 1);
    localparam logic [IDX_W-1:0] HDR_LAST = IDX_W'(HDR_WORDS - 1);
    localparam logic [1:0]       ER_LAST  = 2'(ERASE_N - 1);

    logic blk_end;

    // Last word of the block currently being programmed.
    assign blk_end = sel[0] ? (widx == B1_LAST) : (widx == B0_LAST);

    // Step through the fixed session order one completed command at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            ustep <= '0;
            sel   <= '0;
            widx  <= '0;
        end else if (go) begin
            phase <= PH_ENTER;
            ustep <= '0;
            sel   <= '0;
            widx  <= '0;
        end else if (advance) begin
            if (phase == PH_CHECK) begin
                phase <= verify_ok ? PH_FHDR : PH_EXIT;
                ustep <= '0;
            end else if (!last) begin
                ustep <= ustep + 3'd1;
            end else begin
                ustep <= '0;
                case (phase)
                    PH_ENTER: begin phase <= PH_ERASE; sel <= '0; end
                    PH_ERASE: begin
                        if (sel == ER_LAST) begin phase <= PH_PHDR; sel <= '0; end
                        else sel <= sel + 2'd1;
                    end
                    PH_PHDR: begin phase <= PH_PWORD; widx <= '0; end
                    PH_PWORD: begin
                        if (!blk_end)         widx <= widx + 1'b1;
                        else if (sel == 2'd0) begin phase <= PH_PHDR; sel <= 2'd1; end
                        else                  phase <= PH_CHECK;
                    end
                    PH_FHDR: begin phase <= PH_FWORD; widx <= '0; end
                    PH_FWORD: begin
                        if (widx == HDR_LAST) phase <= PH_EXIT;
                        else                  widx  <= widx + 1'b1;
                    end
                    PH_EXIT: phase <= PH_IDLE;
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/isp_session_seq.sv
// Top of the ISP session sequencer: session control, command handshake to the
// JTAG driver and expected-image read port. Assumes cmd_done is asserted only
// while cmd_valid is high, and rd_data is valid in the cycle rd_blk/rd_idx are.
module isp_session_seq
    import isp_seq_pkg::*;
#(
    parameter int          BLK0_WORDS  = 3328,
    parameter int          BLK1_WORDS  = 512,
    parameter int          HDR_WORDS   = 4,
    parameter logic [23:0] ENTER_IDLE  = 24'd18003,
    parameter logic [23:0] SETUP_IDLE  = 24'd93,
    parameter logic [23:0] ERASE_IDLE  = 24'd9000003,
    parameter logic [23:0] WORD_IDLE   = 24'd1800,
    parameter logic [23:0] LEAVE_IDLE  = 24'd18003,
    parameter logic [23:0] BYPASS_IDLE = 24'd18000,
    localparam int         MAX_WORDS   = (BLK0_WORDS > BLK1_WORDS) ? BLK0_WORDS : BLK1_WORDS,
    localparam int         IDX_W       = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              verify_ok,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic              cmd_valid,
    output logic [1:0]        cmd_kind,
    output logic [9:0]        cmd_ir,
    output logic [4:0]        cmd_dr_len,
    output logic [15:0]       cmd_dr_data,
    output logic [23:0]       cmd_idle,
    input  logic              cmd_done,
    output logic              rd_blk,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic [15:0]       rd_data
);
    phase_e           phase;
    logic [2:0]       ustep;
    logic [1:0]       sel;
    logic [IDX_W-1:0] widx;
    isp_cmd_t         next_cmd;
    isp_cmd_t         cur_cmd;
    logic             last;
    logic             has_cmd;
    logic             go;
    logic             advance;

    // Accept a session request only when idle; step on completion or verify sample.
    assign go      = start && !busy;
    assign advance = (cmd_valid && cmd_done) ||
                     (busy && !cmd_valid && phase == PH_CHECK);

    // Expected image is read only while programming words of a block.
    assign rd_blk = (phase == PH_PWORD) && sel[0];
    assign rd_idx = widx;

    isp_progress #(
        .BLK0_WORDS (BLK0_WORDS),
        .BLK1_WORDS (BLK1_WORDS),
        .HDR_WORDS  (HDR_WORDS),
        .ERASE_N    (3),
        .IDX_W      (IDX_W)
    ) u_prog (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .advance   (advance),
        .last      (last),
        .verify_ok (verify_ok),
        .phase     (phase),
        .ustep     (ustep),
        .sel       (sel),
        .widx      (widx)
    );

    isp_cmd_gen #(
        .IDX_W       (IDX_W),
        .ENTER_IDLE  (ENTER_IDLE),
        .SETUP_IDLE  (SETUP_IDLE),
        .ERASE_IDLE  (ERASE_IDLE),
        .WORD_IDLE   (WORD_IDLE),
        .LEAVE_IDLE  (LEAVE_IDLE),
        .BYPASS_IDLE (BYPASS_IDLE),
        .HDR_MASK    (16'hFBFF)
    ) u_gen (
        .phase   (phase),
        .ustep   (ustep),
        .sel     (sel),
        .widx    (widx),
        .word    (rd_data),
        .cmd     (next_cmd),
        .last    (last),
        .has_cmd (has_cmd)
    );

    // Session control: latch commands, retire them on done, close the session.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            done      <= 1'b0;
            pass      <= 1'b0;
            cmd_valid <= 1'b0;
            cur_cmd   <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy <= 1'b1;
                    pass <= 1'b0;
                end
            end else if (cmd_valid) begin
                if (cmd_done) cmd_valid <= 1'b0;
            end else if (phase == PH_CHECK) begin
                pass <= verify_ok;
            end else if (has_cmd) begin
                cur_cmd   <= next_cmd;
                cmd_valid <= 1'b1;
            end else begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end
    end

    // Present the latched command to the driver.
    assign cmd_kind    = cur_cmd.kind;
    assign cmd_ir      = cur_cmd.ir;
    assign cmd_dr_len  = cur_cmd.len;
    assign cmd_dr_data = cur_cmd.data;
    assign cmd_idle    = cur_cmd.idle;
endmodule

// Protocol checker for the sequencer's handshake and session flags.
module isp_session_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        cmd_valid,
    input logic        cmd_done,
    input logic [1:0]  cmd_kind,
    input logic [9:0]  cmd_ir,
    input logic [4:0]  cmd_dr_len,
    input logic [15:0] cmd_dr_data,
    input logic [23:0] cmd_idle
);
    a_r2_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_done |=> cmd_valid &&
        $stable({cmd_kind, cmd_ir, cmd_dr_len, cmd_dr_data, cmd_idle}));

    a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_done |=> !cmd_valid);

    a_r4_dr_length: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_kind == 2'd1 |-> (cmd_dr_len == 5'd13 || cmd_dr_len == 5'd16));

    a_r10_valid_in_session: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> busy);

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_end_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r12_kind_legal: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cmd_kind != 2'd3);
endmodule

bind isp_session_seq isp_session_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .cmd_valid   (cmd_valid),
    .cmd_done    (cmd_done),
    .cmd_kind    (cmd_kind),
    .cmd_ir      (cmd_ir),
    .cmd_dr_len  (cmd_dr_len),
    .cmd_dr_data (cmd_dr_data),
    .cmd_idle    (cmd_idle)
);

// File: tb/tb_isp_session_seq.sv
module tb_isp_session_seq;
    localparam int B0   = 6;
    localparam int B1   = 3;
    localparam int IDXW = $clog2(B0);
    localparam int MAXC = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic verify_ok = 1'b0;
    logic cmd_done = 1'b0;
    logic busy, done, pass, cmd_valid, rd_blk;
    logic [1:0]  cmd_kind;
    logic [9:0]  cmd_ir;
    logic [4:0]  cmd_dr_len;
    logic [15:0] cmd_dr_data, rd_data;
    logic [23:0] cmd_idle;
    logic [IDXW-1:0] rd_idx;

    always #10 clk = ~clk;

    isp_session_seq #(.BLK0_WORDS(B0), .BLK1_WORDS(B1)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .verify_ok(verify_ok),
        .busy(busy), .done(done), .pass(pass), .cmd_valid(cmd_valid),
        .cmd_kind(cmd_kind), .cmd_ir(cmd_ir), .cmd_dr_len(cmd_dr_len),
        .cmd_dr_data(cmd_dr_data), .cmd_idle(cmd_idle), .cmd_done(cmd_done),
        .rd_blk(rd_blk), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    function automatic logic [15:0] img(input logic b, input int i);
        return 16'hA5C3 ^ {3'b000, b, 12'h000} ^ 16'(i * 16'h0101);
    endfunction

    assign rd_data = img(rd_blk, int'(rd_idx));

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;

    logic [56:0] lg [MAXC];
    int          lg_n = 0;
    logic [56:0] ex [MAXC];
    string       ex_r [MAXC];
    int          ex_n = 0;

    task automatic chk(input bit ok, input string r, input string act, input string exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%s expected=%s", r, act, exp);
        end
    endtask

    function automatic logic [56:0] pack(input logic [1:0] k, input logic [9:0] ir,
                                         input logic [4:0] len, input logic [15:0] d,
                                         input logic [23:0] idl);
        return {k, ir, len, d, idl};
    endfunction

    task automatic push(input logic [1:0] k, input logic [9:0] ir, input logic [4:0] len,
                        input logic [15:0] d, input logic [23:0] idl, input string r);
        ex[ex_n]   = pack(k, ir, len, d, idl);
        ex_r[ex_n] = r;
        ex_n++;
    endtask

    // R4: sector select is instruction 0x203, idle 93, 13-bit sector number.
    task automatic push_sel(input logic [12:0] id, input string r);
        push(2'd0, 10'h203, 5'd0, 16'd0, 24'd0, r);
        push(2'd2, 10'd0, 5'd0, 16'd0, 24'd93, r);
        push(2'd1, 10'd0, 5'd13, {3'b000, id}, 24'd0, r);
    endtask

    task automatic build(input bit ok);
        logic [12:0] er_ids [3];
        ex_n = 0;
        er_ids[0] = 13'h011; er_ids[1] = 13'h001; er_ids[2] = 13'h000;
        push(2'd0, 10'h2CC, 5'd0, 16'd0, 24'd0, "R3");
        push(2'd2, 10'd0, 5'd0, 16'd0, 24'd18003, "R3");
        for (int s = 0; s < 3; s++) begin   // R5 erase order
            push_sel(er_ids[s], "R5");
            push(2'd0, 10'h2F2, 5'd0, 16'd0, 24'd0, "R5");
            push(2'd2, 10'd0, 5'd0, 16'd0, 24'd9000003, "R5");
        end
        for (int b = 0; b < 2; b++) begin   // R6 block programming
            push_sel(13'(b), "R6");
            push(2'd0, 10'h2F4, 5'd0, 16'd0, 24'd0, "R6");
            push(2'd2, 10'd0, 5'd0, 16'd0, 24'd93, "R6");
            for (int i = 0; i < ((b == 0) ? B0 : B1); i++) begin
                push(2'd1, 10'd0, 5'd16, img(b[0], i), 24'd0, "R6");
                push(2'd2, 10'd0, 5'd0, 16'd0, 24'd1800, "R6");
            end
        end
        if (ok) begin                       // R7 header rewrite
            push_sel(13'd0, "R7");
            push(2'd0, 10'h2F4, 5'd0, 16'd0, 24'd0, "R7");
            push(2'd2, 10'd0, 5'd0, 16'd0, 24'd93, "R7");
            for (int i = 0; i < 4; i++) begin
                push(2'd1, 10'd0, 5'd16, (i == 0) ? (img(1'b0, 0) & 16'hFBFF) : img(1'b0, i),
                     24'd0, "R7");
                push(2'd2, 10'd0, 5'd0, 16'd0, 24'd1800, "R7");
            end
        end
        push(2'd0, 10'h201, 5'd0, 16'd0, 24'd0, "R9");
        push(2'd2, 10'd0, 5'd0, 16'd0, 24'd18003, "R9");
        push(2'd0, 10'h3FF, 5'd0, 16'd0, 24'd0, "R9");
        push(2'd2, 10'd0, 5'd0, 16'd0, 24'd18000, "R9");
    endtask

    always @(negedge clk) if (done) done_cnt++;

    // Driver model: log each command, hold done back 0..2 cycles, check R2.
    initial begin
        logic [56:0] cap;
        int d;
        forever begin
            @(negedge clk);
            if (cmd_valid) begin
                cap = pack(cmd_kind, cmd_ir, cmd_dr_len, cmd_dr_data, cmd_idle);
                if (lg_n < MAXC) lg[lg_n] = cap;
                lg_n++;
                d = lg_n % 3;
                repeat (d) begin
                    @(negedge clk);
                    if (!cmd_valid || pack(cmd_kind, cmd_ir, cmd_dr_len, cmd_dr_data, cmd_idle) != cap)
                        chk(1'b0, "R2 fields changed while outstanding",
                            $sformatf("%0h", pack(cmd_kind, cmd_ir, cmd_dr_len, cmd_dr_data, cmd_idle)),
                            $sformatf("%0h", cap));
                end
                cmd_done = 1'b1;
                @(negedge clk);
                cmd_done = 1'b0;
                if (cmd_valid) chk(1'b0, "R2 valid not dropped after done", "1", "0");
            end
        end
    end

    task automatic run_session(input bit ok, input bit poke, input string tag);
        int d0;
        build(ok);
        verify_ok = ok;
        lg_n = 0;
        d0 = done_cnt;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy == 1'b1, "R10 busy after start", $sformatf("%0b", busy), "1");
        if (poke) begin   // R11: stray start mid-session
            repeat (30) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
            chk(busy == 1'b1, "R11 busy kept after stray start", $sformatf("%0b", busy), "1");
        end
        while (busy) @(negedge clk);
        @(negedge clk);
        chk(done_cnt - d0 == 1, {"R10 one done pulse ", tag}, $sformatf("%0d", done_cnt - d0), "1");
        chk(pass == ok, ok ? "R7 pass high" : "R8 pass low", $sformatf("%0b", pass), $sformatf("%0b", ok));
        chk(lg_n == ex_n, ok ? "R7 command count" : "R8 command count",
            $sformatf("%0d", lg_n), $sformatf("%0d", ex_n));
        for (int i = 0; i < ex_n && i < lg_n && i < MAXC; i++)
            chk(lg[i] == ex[i], $sformatf("%s R12 cmd %0d %s", ex_r[i], i, tag),
                $sformatf("%0h", lg[i]), $sformatf("%0h", ex[i]));
        repeat (6) @(negedge clk);
        chk(!busy && !cmd_valid && lg_n == ex_n, "R11 no relaunch after session",
            $sformatf("busy=%0b n=%0d", busy, lg_n), $sformatf("busy=0 n=%0d", ex_n));
        chk(pass == ok, "R10 pass held", $sformatf("%0b", pass), $sformatf("%0b", ok));
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !pass && !cmd_valid, "R1 reset state",
            $sformatf("%0b%0b%0b%0b", busy, done, pass, cmd_valid), "0000");
    endtask

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        test_reset();
        run_session(1'b1, 1'b1, "verify-pass");
        run_session(1'b0, 1'b0, "verify-fail");
        run_session(1'b1, 1'b0, "rerun");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule